// File: doc/BRIEF.md
# Prioritised Address Window Chip-Select Decoder

This block decides which of four programmable address regions owns an outgoing bus access. Each region is described by a base address, a power-of-two size given as the number of low address bits it spans, an enable bit, and a configuration word that carries the region's bus-mode and timing settings. The block compares the captured access address with every enabled region. A fixed override order picks one winner. The block then reports the winning index, hands on that region's configuration word, and pulls down exactly one active-low chip select.

The override order works first inside each pair and then between the pairs. Region 2 beats region 1, and region 4 beats region 3. A hit in the upper pair (3 or 4) beats any hit in the lower pair (1 or 2). An access that no enabled region claims falls to the default region, index 0. That region drives its own chip select and uses a separate default configuration word.

The access address is captured on the clock edge where the access is presented. All outputs are decoded from that captured copy, so they hold steady until the next capture.

Top module: `wdec_top`

## Requirements
- R1: Region k (1..4) claims an address when its enable bit is set and the address bits at and above position `winSizeLog2[k]` equal the same bits of its base. Base bits below that position are ignored. A size code of `ADDR_W` or more claims every address.
- R2: A region whose enable bit is clear never claims an address, whatever its base and size.
- R3: Inside a pair the higher region wins: region 2 over region 1, and region 4 over region 3.
- R4: When regions from both pairs claim an address, the region from the upper pair (3 or 4) wins.
- R5: When no enabled region claims the address during an access, `actIdx` is 0, `actCfg` equals `dfltCfg`, and `csN[0]` is low.
- R6: During an access exactly one bit of `csN` is low. Bit k is low for winning region k, and bit 0 is low for the default region.
- R7: When no access is in progress, all `csN` bits are high and `actIdx` is 0.
- R8: `actCfg` equals the configuration word of the winning region. Region k's word sits at bits `[(k-1)*CFG_W +: CFG_W]` of `winCfg`.
- R9: The address is captured on the rising edge where `accValid` is high. Outputs follow that captured address from that edge on, and do not change when `accAddr` changes between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| accValid | input | 1 | Access presented this cycle |
| accAddr | input | ADDR_W | Access address |
| winEnable | input | 4 | Enable per region, bit k-1 for region k |
| winBase | input | 4*ADDR_W | Base address per region, packed |
| winSizeLog2 | input | 4*SZ_W | Size code per region (log2 of bytes spanned) |
| winCfg | input | 4*CFG_W | Configuration word per region |
| dfltCfg | input | CFG_W | Configuration word of the default region |
| actIdx | output | 3 | Winning region, 0 for default |
| actCfg | output | CFG_W | Configuration of the winning region |
| csN | output | 5 | Active-low one-hot chip selects, bit 0 for default |

## Verification
The bench builds the block with `ADDR_W = 8` and `CFG_W = 4`. This makes the whole 256-address space cheap to sweep for every region layout tried. With an 8-bit address, nested layouts, cross-pair overlaps, unaligned bases, a region that covers the whole space, and disabled regions sitting on matching bases can all be checked at every address against a priority search computed in the bench. Separate probes change `accAddr` between edges and drop `accValid`, to show the capture timing and the idle state.

// File: rtl/wdec_pkg.sv
package wdec_pkg;
  localparam int NUM_WIN = 4;
  localparam int IDX_W   = 3;

  typedef struct packed {
    logic latch;
    logic active;
  } ctrl_t;
endpackage

// File: rtl/wdec_ctrl.sv
module wdec_ctrl
  import wdec_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  accValid,
  output ctrl_t ctrl
);
  logic activeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) activeQ <= 1'b0;
    else       activeQ <= accValid;
  end

  always_comb begin
    ctrl.latch  = accValid;
    ctrl.active = activeQ;
  end

  // R9: an access presented at an edge is in progress after that edge
  p_active_after_req_r9: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> ctrl.active);
  // R7: idle follows a cycle without request
  p_idle_after_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> !ctrl.active);
endmodule

// File: rtl/wdec_datapath.sv
module wdec_datapath
  import wdec_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CFG_W  = 8,
  parameter int SZ_W   = 5
)(
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrl_t                     ctrl,
  input  logic [ADDR_W-1:0]         accAddr,
  input  logic [NUM_WIN-1:0]        winEnable,
  input  logic [NUM_WIN*ADDR_W-1:0] winBase,
  input  logic [NUM_WIN*SZ_W-1:0]   winSizeLog2,
  input  logic [NUM_WIN*CFG_W-1:0]  winCfg,
  input  logic [CFG_W-1:0]          dfltCfg,
  output logic [IDX_W-1:0]          actIdx,
  output logic [CFG_W-1:0]          actCfg,
  output logic [NUM_WIN:0]          csN
);
  logic [ADDR_W-1:0]  addrQ;
  logic [NUM_WIN-1:0] matchVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          addrQ <= '0;
    else if (ctrl.latch) addrQ <= accAddr;
  end

  // masked compare per region
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [ADDR_W-1:0] keepMask;
    logic [SZ_W-1:0]   sizeCode;
    logic [ADDR_W-1:0] baseAddr;
    always_comb begin
      sizeCode = winSizeLog2[w*SZ_W +: SZ_W];
      baseAddr = winBase[w*ADDR_W +: ADDR_W];
      if (int'(sizeCode) >= ADDR_W) keepMask = '0;
      else                          keepMask = {ADDR_W{1'b1}} << sizeCode;
      matchVec[w] = winEnable[w] && (((addrQ ^ baseAddr) & keepMask) == '0);
    end
  end

  // pairwise override, then upper pair over lower pair
  logic            lowHit, highHit;
  logic [IDX_W-1:0] lowPick, highPick, winner;

  always_comb begin
    lowHit   = matchVec[1] | matchVec[0];
    lowPick  = matchVec[1] ? IDX_W'(2) : IDX_W'(1);
    highHit  = matchVec[3] | matchVec[2];
    highPick = matchVec[3] ? IDX_W'(4) : IDX_W'(3);
    if (highHit)     winner = highPick;
    else if (lowHit) winner = lowPick;
    else             winner = '0;
  end

  always_comb begin
    actIdx = ctrl.active ? winner : '0;
    actCfg = dfltCfg;
    for (int k = 1; k <= NUM_WIN; k++) begin
      if (actIdx == IDX_W'(k)) actCfg = winCfg[(k-1)*CFG_W +: CFG_W];
    end
    csN = '1;
    if (ctrl.active) csN[actIdx] = 1'b0;
  end

  // R6: one select low exactly while an access is in progress
  p_cs_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~csN) == (ctrl.active ? 1 : 0));
  // R7: no select when idle
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.active |-> (csN == '1 && actIdx == '0));
  // R5: default select only when nothing claims the address
  p_default_nomatch_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.active && !csN[0]) |-> (matchVec == '0));
  // R4: region 4 beats everything
  p_top_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.active && matchVec[3]) |-> (actIdx == IDX_W'(4)));
  // R3: region 2 beats region 1 when the upper pair is silent
  p_pair_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.active && matchVec[1] && !matchVec[2] && !matchVec[3]) |-> (actIdx == IDX_W'(2)));
  // R9: captured address holds without a request
  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.latch |=> $stable(addrQ));
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_chk
    // R1: a region select implies that region matches
    p_sel_matches_r1: assert property (@(posedge clk) disable iff (!rstN)
      (ctrl.active && !csN[w+1]) |-> matchVec[w]);
    // R2: a disabled region never matches
    p_disabled_r2: assert property (@(posedge clk) disable iff (!rstN)
      !winEnable[w] |-> !matchVec[w]);
  end
endmodule

// File: rtl/wdec_top.sv
module wdec_top
  import wdec_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CFG_W  = 8,
  localparam int SZ_W  = $clog2(ADDR_W + 1)
)(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      accValid,
  input  logic [ADDR_W-1:0]         accAddr,
  input  logic [NUM_WIN-1:0]        winEnable,
  input  logic [NUM_WIN*ADDR_W-1:0] winBase,
  input  logic [NUM_WIN*SZ_W-1:0]   winSizeLog2,
  input  logic [NUM_WIN*CFG_W-1:0]  winCfg,
  input  logic [CFG_W-1:0]          dfltCfg,
  output logic [IDX_W-1:0]          actIdx,
  output logic [CFG_W-1:0]          actCfg,
  output logic [NUM_WIN:0]          csN
);
  ctrl_t ctrl;

  wdec_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .ctrl(ctrl)
  );

  wdec_datapath #(.ADDR_W(ADDR_W), .CFG_W(CFG_W), .SZ_W(SZ_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .accAddr(accAddr),
    .winEnable(winEnable), .winBase(winBase), .winSizeLog2(winSizeLog2),
    .winCfg(winCfg), .dfltCfg(dfltCfg),
    .actIdx(actIdx), .actCfg(actCfg), .csN(csN)
  );
endmodule

// File: tb/wdec_top_tb_top.sv
module wdec_top_tb_top;
  localparam int AW = 8;
  localparam int CW = 4;
  localparam int SW = $clog2(AW + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          accValid = 1'b0;
  logic [AW-1:0] accAddr = '0;
  logic [3:0]    winEnable = '0;
  logic [4*AW-1:0] winBase = '0;
  logic [4*SW-1:0] winSizeLog2 = '0;
  logic [4*CW-1:0] winCfg = '0;
  logic [CW-1:0] dfltCfg = 4'hA;
  logic [2:0]    actIdx;
  logic [CW-1:0] actCfg;
  logic [4:0]    csN;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  wdec_top #(.ADDR_W(AW), .CFG_W(CW)) dut_i (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accAddr(accAddr),
    .winEnable(winEnable), .winBase(winBase), .winSizeLog2(winSizeLog2),
    .winCfg(winCfg), .dfltCfg(dfltCfg),
    .actIdx(actIdx), .actCfg(actCfg), .csN(csN)
  );

  task automatic setWin(int k, bit en, int base, int sz, int cfg);
    winEnable[k-1] = en;
    winBase[(k-1)*AW +: AW] = base[AW-1:0];
    winSizeLog2[(k-1)*SW +: SW] = sz[SW-1:0];
    winCfg[(k-1)*CW +: CW] = cfg[CW-1:0];
  endtask

  // R1 R2 R3 R4: highest claiming enabled region, else 0
  function automatic int expIdx(int a);
    for (int k = 4; k >= 1; k--) begin
      int sz = int'(winSizeLog2[(k-1)*SW +: SW]);
      int b  = int'(winBase[(k-1)*AW +: AW]);
      if (winEnable[k-1] && (sz >= AW || ((a ^ b) >> sz) == 0)) return k;
    end
    return 0;
  endfunction

  function automatic logic [CW-1:0] expCfg(int k);
    if (k == 0) return dfltCfg;
    return winCfg[(k-1)*CW +: CW];
  endfunction

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] pack(int k, bit active);
    logic [4:0] cs;
    cs = active ? ~(5'b1 << k) : 5'h1F;
    return {k[2:0], cs, expCfg(k)};
  endfunction

  task automatic sweep(string req);
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      accValid = 1'b1;
      accAddr  = a[AW-1:0];
      @(negedge clk);
      check(req, {actIdx, csN, actCfg}, pack(expIdx(a), 1'b1));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset", {actIdx, csN, actCfg}, pack(0, 1'b0));
    rstN = 1'b1;
    @(negedge clk);
    check("R7 after reset", {actIdx, csN, actCfg}, pack(0, 1'b0));

    // all disabled, bases that would match
    setWin(1, 0, 8'h00, 8, 1); setWin(2, 0, 8'h40, 6, 2);
    setWin(3, 0, 8'h80, 7, 3); setWin(4, 0, 8'hC0, 6, 4);
    sweep("R2 R5 all disabled");

    // nested regions inside each pair
    setWin(1, 1, 8'h40, 6, 5); setWin(2, 1, 8'h60, 4, 6);
    setWin(3, 1, 8'h80, 6, 7); setWin(4, 1, 8'hA0, 4, 8);
    sweep("R1 R3 R6 R8 pair nesting");

    // cross-pair overlap
    setWin(1, 1, 8'h00, 8, 9);  setWin(2, 1, 8'h10, 4, 10);
    setWin(3, 1, 8'h20, 5, 11); setWin(4, 1, 8'h30, 2, 12);
    sweep("R4 R6 R8 cross pair");

    // unaligned base, disabled overlap, whole-space region
    setWin(1, 1, 8'h4F, 4, 13); setWin(2, 0, 8'h40, 4, 14);
    setWin(3, 0, 8'h00, 8, 15); setWin(4, 1, 8'hF3, 2, 1);
    sweep("R1 R2 unaligned base");
    setWin(3, 1, 8'h00, 9, 15);
    sweep("R1 R4 whole space");

    // R9: capture timing
    setWin(3, 0, 8'h00, 8, 15);
    @(negedge clk); accValid = 1'b1; accAddr = 8'h45;
    @(negedge clk);
    accAddr = 8'hF0;
    #1 check("R9 between edges", {actIdx, csN, actCfg}, pack(1, 1'b1));
    @(negedge clk);
    check("R9 after edge", {actIdx, csN, actCfg}, pack(4, 1'b1));

    // R7: idle
    accValid = 1'b0;
    @(negedge clk);
    check("R7 idle", {actIdx, csN, actCfg}, pack(0, 1'b0));
    accAddr = 8'h45;
    @(negedge clk);
    check("R7 idle addr change", {actIdx, csN, actCfg}, pack(0, 1'b0));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule